// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns internal read, write and instruction-fetch requests into external memory cycles on a 16-bit bus that carries both address and data on the same lines. A request gives a word address, two byte enables and the write data. The block drives the shared lines, an address-latch strobe, a read strobe, a write strobe and a high-lane strobe, and an instruction-fetch flag. It samples a ready input to stretch the data phase, and a width input to choose between a 16-bit and an 8-bit cycle.

Two configuration inputs choose the strobe styles. The latch strobe is either a short pulse at the start of each cycle or a level that stays low for the cycle and rises in its last clock. The write strobes either work as one write strobe plus a high-lane enable, or as two separate lane write strobes. A 16-bit access that meets an 8-bit cycle is carried out as two byte cycles, one after the other. The configuration inputs are expected to stay static while a request is in progress.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is low the block is idle: req_ready is 1, done is 0, and bus_ad_oe and fetch_o are 0. rd_strobe_n, wr_strobe_n and hi_strobe_n are 1. alat_o equals cfg_as_level.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready stays 0 until the cycle ends. done is 1 for exactly one clock, the first clock after the last data clock, and req_ready is 1 again in that same clock. A request presented in that clock is taken at once.
- R3: A bus cycle without wait states has four clocks: address clocks A1 and A2, then data clocks D1 and D2. When cfg_as_level is 0, alat_o is 1 only in A1. When cfg_as_level is 1, alat_o is 0 from A1 through every data clock except the last one, and 1 in the last data clock and while idle.
- R4: A read (req_op 0) or fetch (req_op 2) drives the address in A1 only, and bus_ad_oe is 0 from A2 to the end of the cycle. rd_strobe_n is 0 in every data clock. bus_ad_in is captured at the end of the last data clock and appears on rd_data together with done.
- R5: A write (req_op 1) drives bus_ad_oe to 1 for the whole cycle: the address in the address clocks and the write data in the data clocks. The write strobe is low in D1 and in every wait clock, and high in the last data clock. rd_strobe_n stays 1.
- R6: When cfg_split_wr is 0, wr_strobe_n pulses on every write. hi_strobe_n is 0 over all data clocks of a write that transfers the odd byte, and it stays 1 during reads.
- R7: When cfg_split_wr is 1, wr_strobe_n pulses only when the transfer includes the even byte, and hi_strobe_n pulses with the same timing only when it includes the odd byte.
- R8: wait_rdy is sampled at the end of D1. Each time it is seen low, one wait clock and another D1 follow, so every wait adds two clocks to the strobe width and to the cycle.
- R9: When cfg_dyn_width is 1, wide_i is sampled at the end of A2: 0 selects an 8-bit cycle and 1 selects a 16-bit cycle. When cfg_dyn_width is 0, every cycle is 16-bit and wide_i is ignored.
- R10: req_be[0] marks the even byte, on lines 7:0. req_be[1] marks the odd byte, on lines 15:8. The address on the lines is {req_waddr, odd}, where odd is 1 only for req_be = 2'b10. A 16-bit read returns all 16 lines.
- R11: On an 8-bit cycle, req_be = 2'b11 runs two cycles back to back: the even byte first, then the odd byte at address + 1. Each byte moves on lines 7:0, and lines 15:8 carry the address high byte during write data clocks. A single-byte request runs one cycle, and the rd_data byte that was not read is 0.
- R12: fetch_o is 1 in every clock of the bus cycles of a fetch and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 fetch |
| req_be | input | 2 | Byte enables, bit 0 even byte |
| req_waddr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| cfg_as_level | input | 1 | 0 pulse latch strobe, 1 level strobe |
| cfg_split_wr | input | 1 | 0 write strobe plus high enable, 1 per-lane write strobes |
| cfg_dyn_width | input | 1 | Use wide_i to pick the cycle width |
| bus_ad_out | output | 16 | Address/data lines, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the lines |
| bus_ad_in | input | 16 | Address/data lines, incoming value |
| alat_o | output | 1 | Address latch strobe |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe or even-lane write strobe, active low |
| hi_strobe_n | output | 1 | High-lane enable or odd-lane write strobe, active low |
| fetch_o | output | 1 | Instruction-fetch flag |
| wait_rdy | input | 1 | Ready, low inserts wait states |
| wide_i | input | 1 | Bus width, 1 selects 16 bits |

## Verification
Wait-state insertion and byte splitting can act on the same access. When an 8-bit cycle meets a two-byte request, the ready stretch applies separately to each of the two back-to-back byte cycles, and the second cycle has to begin with the correct odd address and lane strobe. The bench sweeps 0, 1 and 2 waits across every enable pattern, width choice, strobe style and operation. It checks every output on every clock against a phase schedule that it computes from the wait count and from the number of byte cycles. A second collision comes from reusing the completion clock to take the next request, and the bench exercises this on every back-to-back transfer.

// File: rtl/xbus_pkg.sv
// Shared types for the multiplexed external bus controller.
package xbus_pkg;
    // Bus cycle phases: two address clocks, a data clock that may repeat
    // through wait clocks, and a closing data clock.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADR0 = 3'd1,
        ST_ADR1 = 3'd2,
        ST_DAT0 = 3'd3,
        ST_WAIT = 3'd4,
        ST_DAT1 = 3'd5
    } xb_state_t;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_FETCH = 2'd2;
endpackage

// File: rtl/xbus_seq.sv
// Cycle sequencer: holds the accepted request, walks the bus phases,
// inserts wait clocks while ready is low, picks the cycle width and
// chains a second byte cycle when a two-byte access meets an 8-bit cycle.
// Assumes the configuration inputs are static during a request.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [1:0]      req_be,
    input  logic [AD_W-1:1] req_waddr,
    input  logic [AD_W-1:0] req_wdata,
    input  logic            cfg_dyn_width,
    input  logic            wide_i,
    input  logic            wait_rdy,
    output xb_state_t       state,
    output logic            accept,
    output logic [1:0]      op_q,
    output logic [1:0]      be_q,
    output logic [AD_W-1:1] waddr_q,
    output logic [AD_W-1:0] wdata_q,
    output logic            narrow_q,
    output logic            second_q,
    output logic            done_q
);
    logic more_bytes;

    // Request is taken only while idle.
    assign accept     = (state == ST_IDLE) && req_valid;
    // A second byte cycle follows on a narrow two-byte access.
    assign more_bytes = narrow_q && (be_q == 2'b11) && !second_q;

    // Phase register, request hold and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_READ;
            be_q     <= 2'b00;
            waddr_q  <= '0;
            wdata_q  <= '0;
            narrow_q <= 1'b0;
            second_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_ADR0;
                        op_q     <= req_op;
                        be_q     <= req_be;
                        waddr_q  <= req_waddr;
                        wdata_q  <= req_wdata;
                        narrow_q <= 1'b0;
                        second_q <= 1'b0;
                    end
                end
                ST_ADR0: state <= ST_ADR1;
                ST_ADR1: begin
                    state <= ST_DAT0;
                    if (!second_q) begin
                        narrow_q <= cfg_dyn_width && !wide_i;
                    end
                end
                ST_DAT0: state <= wait_rdy ? ST_DAT1 : ST_WAIT;
                ST_WAIT: state <= ST_DAT0;
                ST_DAT1: begin
                    if (more_bytes) begin
                        second_q <= 1'b1;
                        state    <= ST_ADR0;
                    end else begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbus_lanes.sv
// Lane steering: works out which byte the current cycle moves, drives
// address or write data onto the shared lines with their enable, and
// assembles read data. Assumes be_q is never 2'b00.
module xbus_lanes
    import xbus_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  xb_state_t       state,
    input  logic            accept,
    input  logic [1:0]      op_q,
    input  logic [1:0]      be_q,
    input  logic [AD_W-1:1] waddr_q,
    input  logic [AD_W-1:0] wdata_q,
    input  logic            narrow_q,
    input  logic            second_q,
    input  logic [AD_W-1:0] bus_ad_in,
    output logic [1:0]      lanes,
    output logic [AD_W-1:0] bus_ad_out,
    output logic            bus_ad_oe,
    output logic [AD_W-1:0] rd_data
);
    localparam int LW = AD_W / 2;

    logic            cyc_odd;
    logic            is_wr;
    logic [AD_W-1:0] cyc_addr;

    // Odd byte address for a lone high byte or the second narrow cycle.
    assign cyc_odd  = (be_q == 2'b10) || (narrow_q && second_q);
    assign lanes    = narrow_q ? (cyc_odd ? 2'b10 : 2'b01) : be_q;
    assign cyc_addr = {waddr_q, cyc_odd};
    assign is_wr    = (op_q == OP_WRITE);

    // Line drive: address first, then write data; reads float after A1.
    always_comb begin
        bus_ad_out = cyc_addr;
        bus_ad_oe  = 1'b0;
        case (state)
            ST_ADR0: bus_ad_oe = 1'b1;
            ST_ADR1: bus_ad_oe = is_wr;
            ST_DAT0, ST_WAIT, ST_DAT1: begin
                bus_ad_oe  = is_wr;
                bus_ad_out = narrow_q
                    ? {cyc_addr[AD_W-1:LW], cyc_odd ? wdata_q[AD_W-1:LW] : wdata_q[LW-1:0]}
                    : wdata_q;
            end
            default: ;
        endcase
    end

    // Read data capture at the end of the closing data clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (accept) begin
            rd_data <= '0;
        end else if (state == ST_DAT1 && !is_wr) begin
            if (!narrow_q) begin
                rd_data <= bus_ad_in;
            end else if (cyc_odd) begin
                rd_data[AD_W-1:LW] <= bus_ad_in[LW-1:0];
            end else begin
                rd_data[LW-1:0] <= bus_ad_in[LW-1:0];
            end
        end
    end
endmodule

// File: rtl/xbus_strobes.sv
// Strobe decode: latch, read, write and high-lane strobes plus the fetch
// flag, from the phase, the operation and the lanes of the current cycle.
// Pure combinational; outputs change only with registered inputs.
module xbus_strobes
    import xbus_pkg::*;
(
    input  xb_state_t  state,
    input  logic [1:0] op_q,
    input  logic [1:0] lanes,
    input  logic       cfg_as_level,
    input  logic       cfg_split_wr,
    output logic       alat_o,
    output logic       rd_strobe_n,
    output logic       wr_strobe_n,
    output logic       hi_strobe_n,
    output logic       fetch_o
);
    logic is_wr;
    logic in_data;
    logic wr_win;
    logic busy;

    assign is_wr   = (op_q == OP_WRITE);
    assign busy    = (state != ST_IDLE);
    assign in_data = (state == ST_DAT0) || (state == ST_WAIT) || (state == ST_DAT1);
    assign wr_win  = is_wr && ((state == ST_DAT0) || (state == ST_WAIT));

    // Latch strobe: pulse in A1, or level low until the closing clock.
    assign alat_o = cfg_as_level ? !(busy && state != ST_DAT1) : (state == ST_ADR0);

    // Read strobe spans every data clock of a read or fetch.
    assign rd_strobe_n = !(in_data && !is_wr);

    // Write strobes in the selected style.
    always_comb begin
        if (cfg_split_wr) begin
            wr_strobe_n = !(wr_win && lanes[0]);
            hi_strobe_n = !(wr_win && lanes[1]);
        end else begin
            wr_strobe_n = !wr_win;
            hi_strobe_n = !(in_data && is_wr && lanes[1]);
        end
    end

    // Fetch flag covers every clock of a fetch cycle.
    assign fetch_o = busy && (op_q == OP_FETCH);
endmodule

// File: rtl/xbus_ctrl.sv
// Top of the multiplexed external bus controller: sequencer, lane steering
// and strobe decode. Assumes configuration inputs are static per request.
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [1:0]      req_be,
    input  logic [AD_W-1:1] req_waddr,
    input  logic [AD_W-1:0] req_wdata,
    output logic            req_ready,
    output logic            done,
    output logic [AD_W-1:0] rd_data,
    input  logic            cfg_as_level,
    input  logic            cfg_split_wr,
    input  logic            cfg_dyn_width,
    output logic [AD_W-1:0] bus_ad_out,
    output logic            bus_ad_oe,
    input  logic [AD_W-1:0] bus_ad_in,
    output logic            alat_o,
    output logic            rd_strobe_n,
    output logic            wr_strobe_n,
    output logic            hi_strobe_n,
    output logic            fetch_o,
    input  logic            wait_rdy,
    input  logic            wide_i
);
    xb_state_t       state;
    logic            accept;
    logic [1:0]      op_q;
    logic [1:0]      be_q;
    logic [AD_W-1:1] waddr_q;
    logic [AD_W-1:0] wdata_q;
    logic            narrow_q;
    logic            second_q;
    logic [1:0]      lanes;

    // Idle state is the ready indication.
    assign req_ready = (state == ST_IDLE);

    xbus_seq #(.AD_W(AD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_be(req_be), .req_waddr(req_waddr), .req_wdata(req_wdata),
        .cfg_dyn_width(cfg_dyn_width), .wide_i(wide_i), .wait_rdy(wait_rdy),
        .state(state), .accept(accept), .op_q(op_q), .be_q(be_q),
        .waddr_q(waddr_q), .wdata_q(wdata_q), .narrow_q(narrow_q),
        .second_q(second_q), .done_q(done)
    );

    xbus_lanes #(.AD_W(AD_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .state(state), .accept(accept), .op_q(op_q),
        .be_q(be_q), .waddr_q(waddr_q), .wdata_q(wdata_q), .narrow_q(narrow_q),
        .second_q(second_q), .bus_ad_in(bus_ad_in), .lanes(lanes),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .rd_data(rd_data)
    );

    xbus_strobes u_strobes (
        .state(state), .op_q(op_q), .lanes(lanes), .cfg_as_level(cfg_as_level),
        .cfg_split_wr(cfg_split_wr), .alat_o(alat_o), .rd_strobe_n(rd_strobe_n),
        .wr_strobe_n(wr_strobe_n), .hi_strobe_n(hi_strobe_n), .fetch_o(fetch_o)
    );
endmodule

// File: rtl/xbus_ctrl_chk.sv
// Port-level properties of the bus controller, bound to the top module.
module xbus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic bus_ad_oe,
    input logic alat_o,
    input logic rd_strobe_n,
    input logic wr_strobe_n,
    input logic hi_strobe_n,
    input logic fetch_o,
    input logic wait_rdy,
    input logic cfg_as_level
);
    // R4: lines are released whenever the read strobe is active.
    p_float_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_n |-> !bus_ad_oe);

    // R5: read and write strobes are never active together.
    p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strobe_n && !wr_strobe_n));

    // R6: the high-lane strobe stays inactive during reads.
    p_no_hi_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_n |-> hi_strobe_n);

    // R2: completion is flagged in an idle clock.
    p_done_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R12: fetch flag and bus pins are quiet while idle.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !fetch_o && rd_strobe_n && wr_strobe_n && hi_strobe_n && !bus_ad_oe);

    // R3: the latch pulse only falls in an address clock with no strobe active.
    p_latch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_as_level && alat_o) |-> bus_ad_oe && rd_strobe_n && wr_strobe_n && hi_strobe_n);

    // R8: ready low in the first data clock keeps the read strobe low two more clocks.
    p_wait_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_strobe_n) && !wait_rdy) |=> !rd_strobe_n ##1 !rd_strobe_n ##1 !rd_strobe_n);
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .bus_ad_oe(bus_ad_oe), .alat_o(alat_o), .rd_strobe_n(rd_strobe_n),
    .wr_strobe_n(wr_strobe_n), .hi_strobe_n(hi_strobe_n), .fetch_o(fetch_o),
    .wait_rdy(wait_rdy), .cfg_as_level(cfg_as_level)
);

// File: tb/xbus_ctrl_test.sv
// Sweep bench: every op, enable pattern, width choice, strobe style and
// wait count; each clock of each cycle is checked against a computed schedule.
module xbus_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_be = 2'b01;
    logic [15:1] req_waddr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done;
    logic [15:0] rd_data;
    logic        cfg_as_level = 1'b0, cfg_split_wr = 1'b0, cfg_dyn_width = 1'b0;
    logic [15:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [15:0] bus_ad_in = '0;
    logic        alat_o, rd_strobe_n, wr_strobe_n, hi_strobe_n, fetch_o;
    logic        wait_rdy = 1'b1, wide_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_be(req_be), .req_waddr(req_waddr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .cfg_as_level(cfg_as_level), .cfg_split_wr(cfg_split_wr),
        .cfg_dyn_width(cfg_dyn_width), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .alat_o(alat_o),
        .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
        .hi_strobe_n(hi_strobe_n), .fetch_o(fetch_o), .wait_rdy(wait_rdy),
        .wide_i(wide_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One request with the given settings; checks every clock up to the done clock.
    task automatic run_txn(input int op, input logic [1:0] be, input logic [15:1] wa,
                           input logic [15:0] wd, input logic [15:0] rv,
                           input bit lvl, input bit split, input bit dyn,
                           input bit wid, input int waits);
        bit narrow;
        bit is_wr;
        int ncyc;
        int nclk;
        logic [15:0] exp_rd;
        narrow = dyn && !wid;
        is_wr  = (op == 1);
        ncyc   = (narrow && be == 2'b11) ? 2 : 1;
        nclk   = 4 + 2 * waits;
        cfg_as_level = lvl; cfg_split_wr = split; cfg_dyn_width = dyn; wide_i = wid;
        wait_rdy = 1'b1;
        req_valid = 1'b1; req_op = op[1:0]; req_be = be; req_waddr = wa; req_wdata = wd;
        @(posedge clk);
        for (int c = 0; c < ncyc; c++) begin
            bit odd;
            logic [1:0] ln;
            logic [15:0] ca;
            logic [15:0] wexp;
            odd  = (be == 2'b10) || (narrow && c == 1);
            ln   = narrow ? (odd ? 2'b10 : 2'b01) : be;
            ca   = {wa, odd};
            wexp = narrow ? {ca[15:8], odd ? wd[15:8] : wd[7:0]} : wd;
            for (int k = 0; k < nclk; k++) begin
                int ph;
                bit e_oe, e_wrwin;
                if (k < 2) ph = k + 1;
                else if (k == nclk - 1) ph = 5;
                else ph = ((k - 2) % 2 == 0) ? 3 : 4;
                @(negedge clk);
                req_valid = 1'b0;
                wait_rdy  = !(ph == 3 && k < nclk - 2);
                bus_ad_in = narrow ? {8'hA5, odd ? rv[15:8] : rv[7:0]} : rv;
                e_oe    = (ph == 1) || is_wr;
                e_wrwin = is_wr && (ph == 3 || ph == 4);
                chk("R2/R8", "req_ready busy", req_ready, 0);
                chk("R2", "done busy", done, 0);
                chk("R3", "alat_o", alat_o, lvl ? (ph == 5) : (ph == 1));
                chk(is_wr ? "R5" : "R4", "bus_ad_oe", bus_ad_oe, e_oe);
                if (e_oe && ph <= 2) chk("R10/R11", "address", bus_ad_out, ca);
                if (e_oe && ph >= 3) chk("R5/R9/R11", "write data", bus_ad_out, wexp);
                chk("R4/R8", "rd_strobe_n", rd_strobe_n, !(!is_wr && ph >= 3));
                if (split) begin
                    chk("R7", "wr_strobe_n", wr_strobe_n, !(e_wrwin && ln[0]));
                    chk("R7", "hi_strobe_n", hi_strobe_n, !(e_wrwin && ln[1]));
                end else begin
                    chk("R6/R8", "wr_strobe_n", wr_strobe_n, !e_wrwin);
                    chk("R6", "hi_strobe_n", hi_strobe_n, !(is_wr && ph >= 3 && ln[1]));
                end
                chk("R12", "fetch_o", fetch_o, op == 2);
            end
        end
        @(negedge clk);
        if (!narrow || be == 2'b11) exp_rd = rv;
        else if (be == 2'b01) exp_rd = {8'h00, rv[7:0]};
        else exp_rd = {rv[15:8], 8'h00};
        chk("R2", "done end", done, 1);
        chk("R2", "req_ready end", req_ready, 1);
        chk("R3", "alat_o idle", alat_o, lvl);
        chk("R12", "fetch_o idle", fetch_o, 0);
        chk("R4/R5", "strobes idle", {rd_strobe_n, wr_strobe_n, hi_strobe_n, bus_ad_oe}, 4'b1110);
        if (!is_wr) chk("R4/R9/R10/R11", "rd_data", rd_data, exp_rd);
    endtask

    initial begin
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state in both latch styles.
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "done", done, 0);
        chk("R1", "oe/fetch", {bus_ad_oe, fetch_o}, 2'b00);
        chk("R1", "strobes", {rd_strobe_n, wr_strobe_n, hi_strobe_n}, 3'b111);
        chk("R1", "alat_o pulse style", alat_o, 0);
        cfg_as_level = 1'b1;
        #1;
        chk("R1", "alat_o level style", alat_o, 1);
        rst_n = 1'b1;
        for (int lvl = 0; lvl < 2; lvl++)
            for (int sp = 0; sp < 2; sp++)
                for (int op = 0; op < 3; op++)
                    for (int b = 1; b < 4; b++)
                        for (int wm = 0; wm < 3; wm++)
                            for (int w = 0; w < 3; w++) begin
                                n++;
                                run_txn(op, 2'(b), 15'(n * 389 + 7), 16'(16'hA000 ^ (n * 4951)),
                                        16'(16'h5A00 + n * 773), lvl[0], sp[0],
                                        wm != 0, wm == 2, w);
                            end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule